// File: doc/BRIEF.md
# Trap and Privilege Control Unit

This block holds the privilege state of a simple processor and performs every transfer of control into and out of kernel mode. It accepts trap requests from the commit stage of the pipeline: page faults, divide-by-zero faults, privileged instructions attempted from user mode, system calls, a built-in programmable timer and a device interrupt line. When it accepts a request it acts in a single cycle. It redirects the fetch unit to the handler vector, loads the kernel stack pointer and flushes the pipeline. On the next clock edge it has stored the return PC, the user stack pointer, the prior mode and a cause code, and it is in kernel mode.

Once a trap is taken, further traps are held off until the handler acknowledges it or returns. Synchronous requests that arrive during that window are dropped. The interrupt sources stay pending. The return-from-trap operation restores the saved mode, stack pointer and PC in one step. After reset the block is in kernel mode with traps held off, and for one cycle it redirects fetch to the boot address.

Top module: `trap_ctrl`

## Requirements
- R1: In the first cycle after reset, redirect_o is 1, redirect_pc_o is BOOT_ADDR (default 0xBFC00000), mode_o is 1 (kernel; 0 means user) and busy_o is 1 (traps held off). All saved registers, the kernel stack pointer and the timer period are 0.
- R2: When a trap is taken (valid_i is 1, a request is active and busy_o is 0), in that same cycle redirect_o, flush_o and sp_load_o are 1, redirect_pc_o is VECTOR (0x80000180) and sp_o is the kernel stack pointer. From the next cycle mode_o is 1 and busy_o is 1.
- R3: A taken trap stores the values present in its cycle. epc_o takes pc_i, saved_sp_o takes sp_i, saved_mode_o takes the mode before the trap and cause_o takes the cause code.
- R4: Cause codes are 0 for the device interrupt, 1 for the timer tick, 2 for a page fault, 3 for divide-by-zero, 4 for a system call and 5 for a privilege violation. When several requests arrive together, the order of priority is page fault, divide-by-zero, privilege violation, system call, timer, device.
- R5: bad_vaddr_o takes badaddr_i only when the trap taken is a page fault. Any other trap leaves it unchanged.
- R6: While busy_o is 1, no trap is taken and the saved registers do not change. Synchronous requests are dropped. A pending timer tick, or irq_i held high, is taken once traps are enabled again.
- R7: A return (valid_i and eret_i in kernel mode, with no trap taken) drives redirect_o, flush_o and sp_load_o to 1, redirect_pc_o to epc_o and sp_o to saved_sp_o. On the next edge mode_o becomes saved_mode_o and busy_o becomes 0.
- R8: In user mode, priv_instr_i or eret_i raises a trap with cause 5. In kernel mode, priv_instr_i raises no trap.
- R9: When the timer period P is nonzero, a tick becomes pending P cycles after the period is written, and then again every P cycles. A pending tick stays pending until a trap with cause 1 is taken. A period of 0 stops the timer.
- R10: cfg_we_i writes the kernel stack pointer (cfg_sel_i is 0) or the timer period (cfg_sel_i is 1), but only in kernel mode. In user mode the write has no effect.
- R11: ack_i in kernel mode clears busy_o on the next edge without changing the mode, which allows nested traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | An instruction is at the commit point |
| pc_i | input | XLEN | PC of the committing instruction |
| sp_i | input | XLEN | Current stack pointer |
| pgfault_i | input | 1 | Page fault on the committing instruction |
| badaddr_i | input | XLEN | Faulting virtual address |
| div0_i | input | 1 | Divide-by-zero fault |
| syscall_i | input | 1 | System-call instruction |
| priv_instr_i | input | 1 | Instruction needs kernel mode |
| eret_i | input | 1 | Return-from-trap instruction |
| irq_i | input | 1 | Device interrupt level |
| ack_i | input | 1 | Handler re-enables traps |
| cfg_we_i | input | 1 | Kernel register write |
| cfg_sel_i | input | 1 | 0 selects the kernel stack pointer, 1 selects the timer period |
| cfg_data_i | input | XLEN | Write data |
| mode_o | output | 1 | 1 = kernel, 0 = user |
| busy_o | output | 1 | Traps held off |
| redirect_o | output | 1 | Fetch redirect |
| redirect_pc_o | output | XLEN | Redirect target |
| flush_o | output | 1 | Pipeline flush pulse |
| sp_load_o | output | 1 | Load sp_o into the stack pointer |
| sp_o | output | XLEN | Stack pointer value to load |
| epc_o | output | XLEN | Saved return PC |
| cause_o | output | 4 | Saved cause code |
| saved_mode_o | output | 1 | Mode before the last trap |
| saved_sp_o | output | XLEN | Stack pointer before the last trap |
| bad_vaddr_o | output | XLEN | Last faulting address |

## Verification
The bench drives every source at once, and also in pairs, to show that the priority order holds. A wrong order would store the wrong cause code and, for a page fault, lose the bad address. It sends faults and system calls while a trap is outstanding, where a design without a hold-off would overwrite the saved PC and cause. It holds irq_i high through a return and lets a timer tick land while busy, to show that interrupts are not lost. It tries an eret and a configuration write from user mode, where a design that skipped the mode check would drop to an unknown mode or swap in a stack pointer written from user mode. It also takes a nested trap from kernel mode, which must save mode 1 and return to kernel.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [3:0] {
    CAUSE_DEV_IRQ    = 4'd0,
    CAUSE_CLOCK_TICK = 4'd1,
    CAUSE_PAGE_FAULT = 4'd2,
    CAUSE_DIV_ZERO   = 4'd3,
    CAUSE_SYSCALL    = 4'd4,
    CAUSE_PRIV       = 4'd5
  } cause_e;

  // request slots, index 0 = highest priority
  localparam int NUM_SRC = 6;
  localparam int SRC_PGF  = 0;
  localparam int SRC_DIV  = 1;
  localparam int SRC_PRIV = 2;
  localparam int SRC_SYS  = 3;
  localparam int SRC_TICK = 4;
  localparam int SRC_DEV  = 5;

  function automatic cause_e src_cause(int idx);
    case (idx)
      SRC_PGF:  return CAUSE_PAGE_FAULT;
      SRC_DIV:  return CAUSE_DIV_ZERO;
      SRC_PRIV: return CAUSE_PRIV;
      SRC_SYS:  return CAUSE_SYSCALL;
      SRC_TICK: return CAUSE_CLOCK_TICK;
      default:  return CAUSE_DEV_IRQ;
    endcase
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         en_i,
  output logic         take_o,
  output logic [N-1:0] grant_o,
  output cause_e       cause_o
);
  logic [N-1:0] first;

  always_comb begin
    first = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) first = '0;
      if (req_i[i]) first[i] = 1'b1;
    end
  end

  assign grant_o = en_i ? first : '0;
  assign take_o  = |grant_o;

  always_comb begin
    cause_o = CAUSE_DEV_IRQ;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) cause_o = src_cause(i);
  end

  p_grant_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  p_top_priority_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && req_i[0]) |-> grant_o[0]);
  p_no_grant_when_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !take_o);
endmodule

// File: rtl/trap_timer.sv
module trap_timer #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         period_we_i,
  input  logic [W-1:0] period_i,
  input  logic         accept_i,
  output logic         pend_o
);
  logic [W-1:0] period_q, cnt_q;
  logic         pend_q, tick;

  assign tick = (period_q != '0) && (cnt_q == period_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (period_we_i) begin
        period_q <= period_i;
        cnt_q    <= '0;
      end else if (tick || period_q == '0) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (tick)          pend_q <= 1'b1;
      else if (accept_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  p_pend_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !accept_i) |=> pend_q);
  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_q != '0) |-> (cnt_q < period_q));
endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  cause_e          cause_i,
  input  logic            pgf_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] badaddr_i,
  input  logic            eret_i,
  input  logic            ack_i,
  input  logic            ksp_we_i,
  input  logic [XLEN-1:0] ksp_i,
  output logic            mode_o,
  output logic            busy_o,
  output logic            boot_o,
  output logic [XLEN-1:0] epc_o,
  output cause_e          cause_o,
  output logic [XLEN-1:0] bad_vaddr_o,
  output logic [XLEN-1:0] saved_sp_o,
  output logic            saved_mode_o,
  output logic [XLEN-1:0] ksp_o
);
  logic            mode_q, busy_q, boot_q, smode_q;
  logic [XLEN-1:0] epc_q, bad_q, ssp_q, ksp_q;
  cause_e          cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b1;
      busy_q  <= 1'b1;
      boot_q  <= 1'b1;
      smode_q <= 1'b0;
      epc_q   <= '0;
      bad_q   <= '0;
      ssp_q   <= '0;
      ksp_q   <= '0;
      cause_q <= CAUSE_DEV_IRQ;
    end else begin
      boot_q <= 1'b0;
      if (take_i) begin
        mode_q  <= 1'b1;
        busy_q  <= 1'b1;
        epc_q   <= pc_i;
        ssp_q   <= sp_i;
        smode_q <= mode_q;
        cause_q <= cause_i;
        if (pgf_i) bad_q <= badaddr_i;
      end else if (eret_i) begin
        mode_q <= smode_q;
        busy_q <= 1'b0;
      end else if (ack_i) begin
        busy_q <= 1'b0;
      end
      if (ksp_we_i) ksp_q <= ksp_i;
    end
  end

  assign mode_o       = mode_q;
  assign busy_o       = busy_q;
  assign boot_o       = boot_q;
  assign epc_o        = epc_q;
  assign cause_o      = cause_q;
  assign bad_vaddr_o  = bad_q;
  assign saved_sp_o   = ssp_q;
  assign saved_mode_o = smode_q;
  assign ksp_o        = ksp_q;

  p_trap_enters_kernel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (mode_q && busy_q));
  p_saved_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(epc_q) && $stable(cause_q) && $stable(ssp_q)));
  p_eret_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !take_i) |=> (mode_q == $past(smode_q) && !busy_q));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              TIMER_W   = XLEN,
  parameter logic [XLEN-1:0] VECTOR    = 32'h8000_0180,
  parameter logic [XLEN-1:0] BOOT_ADDR = 32'hBFC0_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic            pgfault_i,
  input  logic [XLEN-1:0] badaddr_i,
  input  logic            div0_i,
  input  logic            syscall_i,
  input  logic            priv_instr_i,
  input  logic            eret_i,
  input  logic            irq_i,
  input  logic            ack_i,
  input  logic            cfg_we_i,
  input  logic            cfg_sel_i,
  input  logic [XLEN-1:0] cfg_data_i,
  output logic            mode_o,
  output logic            busy_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            flush_o,
  output logic            sp_load_o,
  output logic [XLEN-1:0] sp_o,
  output logic [XLEN-1:0] epc_o,
  output logic [3:0]      cause_o,
  output logic            saved_mode_o,
  output logic [XLEN-1:0] saved_sp_o,
  output logic [XLEN-1:0] bad_vaddr_o
);
  logic [NUM_SRC-1:0] req, grant;
  logic               take, eret_do, ack_do, kern, boot, tick_pend;
  logic [XLEN-1:0]    ksp, epc, ssp;
  cause_e             take_cause, saved_cause;

  assign kern = mode_o;

  always_comb begin
    req           = '0;
    req[SRC_PGF]  = pgfault_i;
    req[SRC_DIV]  = div0_i;
    req[SRC_PRIV] = (priv_instr_i || eret_i) && !kern;
    req[SRC_SYS]  = syscall_i;
    req[SRC_TICK] = tick_pend;
    req[SRC_DEV]  = irq_i;
    if (!valid_i) req = '0;
  end

  trap_arbiter #(.N(NUM_SRC)) u_arb (
    .clk_i, .rst_ni,
    .req_i  (req),
    .en_i   (!busy_o),
    .take_o (take),
    .grant_o(grant),
    .cause_o(take_cause)
  );

  trap_timer #(.W(TIMER_W)) u_timer (
    .clk_i, .rst_ni,
    .period_we_i(cfg_we_i && cfg_sel_i && kern),
    .period_i   (cfg_data_i[TIMER_W-1:0]),
    .accept_i   (grant[SRC_TICK]),
    .pend_o     (tick_pend)
  );

  assign eret_do = valid_i && eret_i && kern && !take && !boot;
  assign ack_do  = ack_i && kern;

  trap_state #(.XLEN(XLEN)) u_state (
    .clk_i, .rst_ni,
    .take_i      (take),
    .cause_i     (take_cause),
    .pgf_i       (grant[SRC_PGF]),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .badaddr_i   (badaddr_i),
    .eret_i      (eret_do),
    .ack_i       (ack_do),
    .ksp_we_i    (cfg_we_i && !cfg_sel_i && kern),
    .ksp_i       (cfg_data_i),
    .mode_o      (mode_o),
    .busy_o      (busy_o),
    .boot_o      (boot),
    .epc_o       (epc),
    .cause_o     (saved_cause),
    .bad_vaddr_o (bad_vaddr_o),
    .saved_sp_o  (ssp),
    .saved_mode_o(saved_mode_o),
    .ksp_o       (ksp)
  );

  assign epc_o      = epc;
  assign saved_sp_o = ssp;
  assign cause_o    = saved_cause;

  assign flush_o       = take || eret_do;
  assign sp_load_o     = take || eret_do;
  assign redirect_o    = take || eret_do || boot;
  assign redirect_pc_o = take ? VECTOR : (eret_do ? epc : BOOT_ADDR);
  assign sp_o          = take ? ksp : ssp;

  p_hold_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !flush_o || (eret_i && kern));
  p_vector_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !(valid_i && eret_i && kern)) |-> (redirect_pc_o == VECTOR));
  p_priv_trap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && priv_instr_i && !kern && !busy_o) |-> flush_o);
  p_trap_saves_pc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !busy_o && !(valid_i && eret_i && kern)) |=> (epc_o == $past(pc_i)));
endmodule

// File: tb/tb_trap_ctrl.sv
`timescale 1ns/1ps
module tb_trap_ctrl;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        valid_i = 0, pgfault_i = 0, div0_i = 0, syscall_i = 0;
  logic        priv_instr_i = 0, eret_i = 0, irq_i = 0, ack_i = 0;
  logic        cfg_we_i = 0, cfg_sel_i = 0;
  logic [31:0] pc_i = 0, sp_i = 0, badaddr_i = 0, cfg_data_i = 0;
  logic        mode_o, busy_o, redirect_o, flush_o, sp_load_o, saved_mode_o;
  logic [31:0] redirect_pc_o, sp_o, epc_o, saved_sp_o, bad_vaddr_o;
  logic [3:0]  cause_o;

  always #2 clk = ~clk;

  trap_ctrl dut (.clk_i(clk), .*);

  int checks = 0, errors = 0;
  bit done = 0;
  string tag;

  // reference state
  bit          m_mode, m_busy, m_boot, m_smode, m_pend;
  logic [31:0] m_epc, m_bad, m_ssp, m_ksp;
  int          m_cause, m_per, m_cnt;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(string t);
    bit pf, dz, pv, sc, tk, dv, take, er, tick;
    int c;
    logic [31:0] rpc, spx;
    tag = t;
    #1;
    pf = valid_i && pgfault_i; dz = valid_i && div0_i;
    pv = valid_i && (priv_instr_i || eret_i) && !m_mode;
    sc = valid_i && syscall_i; tk = valid_i && m_pend; dv = valid_i && irq_i;
    take = !m_busy && (pf || dz || pv || sc || tk || dv);
    c = pf ? 2 : dz ? 3 : pv ? 5 : sc ? 4 : tk ? 1 : 0;
    er = valid_i && eret_i && m_mode && !take && !m_boot;
    rpc = take ? 32'h8000_0180 : (er ? m_epc : 32'hBFC0_0000);
    spx = take ? m_ksp : m_ssp;
    chk("mode", mode_o, m_mode);
    chk("busy", busy_o, m_busy);
    chk("redirect", redirect_o, take || er || m_boot);
    if (take || er || m_boot) chk("redirect_pc", redirect_pc_o, rpc);
    chk("flush", flush_o, take || er);
    chk("sp_load", sp_load_o, take || er);
    chk("sp", sp_o, spx);
    chk("epc", epc_o, m_epc);
    chk("cause", cause_o, c[3:0] & 4'h0 | m_cause[3:0]);
    chk("saved_mode", saved_mode_o, m_smode);
    chk("saved_sp", saved_sp_o, m_ssp);
    chk("bad_vaddr", bad_vaddr_o, m_bad);
    // timer
    tick = (m_per != 0) && (m_cnt == m_per - 1);
    if (cfg_we_i && cfg_sel_i && m_mode) begin m_per = int'(cfg_data_i); m_cnt = 0; end
    else if (tick || m_per == 0) m_cnt = 0;
    else m_cnt++;
    if (tick) m_pend = 1;
    else if (take && c == 1) m_pend = 0;
    if (cfg_we_i && !cfg_sel_i && m_mode) m_ksp = cfg_data_i;
    m_boot = 0;
    if (take) begin
      m_smode = m_mode; m_mode = 1; m_busy = 1;
      m_epc = pc_i; m_ssp = sp_i; m_cause = c;
      if (pf) m_bad = badaddr_i;
    end else if (er) begin
      m_mode = m_smode; m_busy = 0;
    end else if (ack_i && m_mode) m_busy = 0;
    @(negedge clk);
    valid_i = 0; pgfault_i = 0; div0_i = 0; syscall_i = 0; priv_instr_i = 0;
    eret_i = 0; ack_i = 0; cfg_we_i = 0; cfg_sel_i = 0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_mode = 1; m_busy = 1; m_boot = 1; m_smode = 0; m_pend = 0;
    m_epc = 0; m_bad = 0; m_ssp = 0; m_ksp = 0; m_cause = 0; m_per = 0; m_cnt = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    cyc("R1");                                            // boot redirect
    cyc("R1");
    cfg_we_i = 1; cfg_sel_i = 0; cfg_data_i = 32'h8FFF_0000; cyc("R10");
    ack_i = 1; cyc("R11");
    valid_i = 1; eret_i = 1; pc_i = 32'h8000_0200; cyc("R7");   // drop to user
    cyc("R7");
    valid_i = 1; syscall_i = 1; pc_i = 32'h0040_0100; sp_i = 32'h7FFF_FF00; cyc("R2");
    cyc("R3");
    valid_i = 1; div0_i = 1; syscall_i = 1; pc_i = 32'h8000_0300; cyc("R6");
    valid_i = 1; pgfault_i = 1; badaddr_i = 32'h5555_0000; cyc("R6");
    cyc("R6");
    valid_i = 1; eret_i = 1; cyc("R7");
    valid_i = 1; pgfault_i = 1; div0_i = 1; syscall_i = 1; irq_i = 1;
    badaddr_i = 32'h1234_5000; pc_i = 32'h0040_0200; sp_i = 32'h7FFF_FE00; cyc("R4");
    irq_i = 0; cyc("R5");
    valid_i = 1; eret_i = 1; cyc("R7");
    valid_i = 1; div0_i = 1; syscall_i = 1; pc_i = 32'h0040_0300; cyc("R4");
    valid_i = 1; eret_i = 1; cyc("R7");
    valid_i = 1; syscall_i = 1; priv_instr_i = 1; pc_i = 32'h0040_0400; cyc("R8");
    valid_i = 1; eret_i = 1; cyc("R7");
    valid_i = 1; eret_i = 1; pc_i = 32'h0040_0500; cyc("R8");   // eret from user
    cyc("R8");
    valid_i = 1; eret_i = 1; cyc("R7");
    cfg_we_i = 1; cfg_sel_i = 0; cfg_data_i = 32'hDEAD_0000; cyc("R10");
    valid_i = 1; syscall_i = 1; pc_i = 32'h0040_0600; cyc("R10");
    irq_i = 1;
    for (int i = 0; i < 3; i++) begin valid_i = 1; cyc("R6"); end
    valid_i = 1; eret_i = 1; cyc("R6");
    valid_i = 1; pc_i = 32'h0040_0700; cyc("R6");               // pending irq taken
    irq_i = 0; cyc("R6");
    ack_i = 1; cyc("R11");
    valid_i = 1; syscall_i = 1; pc_i = 32'h8000_0400; sp_i = 32'h8FFF_0000; cyc("R3");
    valid_i = 1; eret_i = 1; cyc("R7");
    cfg_we_i = 1; cfg_sel_i = 1; cfg_data_i = 6; cyc("R9");
    for (int i = 0; i < 10; i++) begin valid_i = 1; pc_i = 32'h8000_0500 + i; cyc("R9"); end
    for (int i = 0; i < 8; i++) begin valid_i = (i > 5); cyc("R9"); end
    ack_i = 1; cyc("R9");
    valid_i = 1; cyc("R9");
    cfg_we_i = 1; cfg_sel_i = 1; cfg_data_i = 0; cyc("R9");
    ack_i = 1; cyc("R11");
    for (int i = 0; i < 10; i++) begin valid_i = 1; cyc("R9"); end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule